// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block turns a configuration-space request into a single word-aligned downstream bus address and a value for the window register that sits in front of that address. A request names a bus, a device, a function, a byte offset, an access size of 1, 2 or 4 bytes, and a direction. Requests on bus zero become type 0 cycles, where the device is chosen by a one-hot select line. The select line is split at a window boundary: the upper select bits go into the window register and the lower ones go into the address. Requests on any other bus become type 1 cycles, where bus, device and function are packed into the address as fields.

The downstream side only moves whole 32-bit words. The block therefore aligns sub-word read data onto the low byte lanes. Byte and halfword writes are done as a read, a lane merge and a write-back of the same word. Malformed requests finish at once with an error and cause no bus traffic. A bus error reported by the target finishes the request with an error and an all-ones result. A valid/ready handshake accepts one request at a time, and a one-cycle done pulse returns the error flag and the read result.

Top module: `cfgx_translator`

## Requirements
- R1: With reqBus = 0, let S = 1 << (reqDev + 16). The window register is loaded with TYPE0_CODE (default 0x2) OR (S AND WIN_MASK). WIN_MASK defaults to 0xFC000000. The bus address is CFG_BASE (default 0x0C000000) OR (S AND NOT WIN_MASK) OR reqFunc<<8 OR the offset with bits 1:0 cleared. Every bus address has bits 1:0 equal to zero.
- R2: With reqBus = 0 and reqDev of 16 or more, the request is rejected.
- R3: With reqBus ≠ 0, the window register is loaded with TYPE1_CODE (default 0x3). The address is CFG_BASE OR reqBus<<16 OR reqDev<<11 OR reqFunc<<8 OR the offset with bits 1:0 cleared.
- R4: A reqSize value other than 1, 2 or 4 is rejected.
- R5: When singleSlot is high at acceptance, any reqDev above 1 is rejected, on any bus.
- R6: A rejected request finishes with doneErr = 1 and doneRdata = 0. It makes no bus access and leaves winValue unchanged.
- R7: A read returns the fetched word shifted right by 8 × (offset mod 4) and masked to the access size. Size 4 keeps all 32 bits of the shifted word.
- R8: A 1- or 2-byte write performs exactly one bus read and then one bus write to the same address. The written word equals the read word with the target lanes replaced by the write data shifted left by 8 × (offset mod 4).
- R9: A 4-byte write performs exactly one bus write of reqWdata unchanged, with no bus read.
- R10: A bus error finishes the request with doneErr = 1 and doneRdata = 0xFFFFFFFF. If the error comes on the read half of a merged write, the write half is not issued.
- R11: reqReady is high only while no request is in flight. done is a one-cycle pulse. busReq holds its address stable until busAck. doneRdata is 0 for a completed write that had no error.
- R12: After reset, reqReady = 1, done = 0, busReq = 0 and winValue = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleSlot | input | 1 | Only devices 0 and 1 are reachable |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted on valid |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOff | input | 8 | Byte offset in configuration space |
| reqSize | input | 3 | Access size in bytes |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Completion error flag |
| doneRdata | output | 32 | Aligned read result |
| winValue | output | 32 | Window register contents |
| busReq | output | 1 | Downstream access request |
| busWrite | output | 1 | Downstream access is a write |
| busAddr | output | 32 | Downstream word address |
| busWdata | output | 32 | Downstream write word |
| busAck | input | 1 | Downstream access complete |
| busErr | input | 1 | Downstream error, valid with busAck |
| busRdata | input | 32 | Downstream read word, valid with busAck |

## Verification
The assertions check the protocol on every cycle. They cover the done pulse width, a quiet bus while idle, address hold until acknowledge, word alignment of the address, and the rule that a completion without bus activity must carry an error. They also check that an errored access ends with an all-ones result and that no write follows it. Only the bench's sweeps can show that the address and window fields are correct for each device, bus and function. The same holds for the shifted read lanes and the merged write word at every offset and size, and for the exact number of reads and writes each request makes.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } cfgxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadWin;
    logic markBad;
    logic captureRead;
    logic captureWrite;
  } cfgxCtrl_t;

  // decode results from datapath to control
  typedef struct packed {
    logic bad;
    logic needRead;
    logic isWrite;
  } cfgxDecode_t;

endpackage

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FUNC_W     = 3,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int SLOT_COUNT = 16,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] TYPE0_CODE = 32'h0000_0002,
  parameter logic [31:0] TYPE1_CODE = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgxCtrl_t         ctrl,
  input  logic              singleSlot,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busRdata,
  input  logic              busErr,
  output cfgxDecode_t       dec,
  output logic [31:0]       busAddr,
  output logic [31:0]       busWdata,
  output logic [31:0]       winValue,
  output logic              doneErr,
  output logic [31:0]       doneRdata
);

  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / 8;
  localparam int SEL_LSB    = 16;
  localparam int BUS_SHIFT  = 16;
  localparam int DEV_SHIFT  = 11;
  localparam int FUNC_SHIFT = 8;
  localparam int SEL_W      = $clog2(SEL_LSB + (1 << DEV_W)) + 1;

  logic [BUS_W-1:0]  busQ;
  logic [DEV_W-1:0]  devQ;
  logic [FUNC_W-1:0] funcQ;
  logic [OFF_W-1:0]  offQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              writeQ;
  logic              singleQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] wordQ;
  logic [DATA_W-1:0] winQ;
  logic              badQ;
  logic              busErrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ    <= '0;
      devQ    <= '0;
      funcQ   <= '0;
      offQ    <= '0;
      sizeQ   <= '0;
      writeQ  <= 1'b0;
      singleQ <= 1'b0;
      wdataQ  <= '0;
      wordQ   <= '0;
      winQ    <= '0;
      badQ    <= 1'b0;
      busErrQ <= 1'b0;
    end else begin
      if (ctrl.latchReq) begin
        busQ    <= reqBus;
        devQ    <= reqDev;
        funcQ   <= reqFunc;
        offQ    <= reqOff;
        sizeQ   <= reqSize;
        writeQ  <= reqWrite;
        singleQ <= singleSlot;
        wdataQ  <= reqWdata;
        badQ    <= 1'b0;
        busErrQ <= 1'b0;
      end
      if (ctrl.markBad) badQ <= 1'b1;
      if (ctrl.loadWin) winQ <= winNext;
      if (ctrl.captureRead) begin
        wordQ <= busRdata;
        if (busErr) busErrQ <= 1'b1;
      end
      if (ctrl.captureWrite && busErr) busErrQ <= 1'b1;
    end
  end

  // ---- request decode ----
  logic sizeOk, isType0, devRangeBad, slotBad;
  logic [SEL_W-1:0] selBit;
  logic [DATA_W-1:0] oneHot, funcField, offField, t0Addr, t1Addr, winNext;

  always_comb begin
    sizeOk      = (sizeQ == SIZE_W'(1)) || (sizeQ == SIZE_W'(2)) || (sizeQ == SIZE_W'(4));
    isType0     = (busQ == '0);
    devRangeBad = isType0 && (32'(devQ) >= SLOT_COUNT);
    slotBad     = singleQ && (devQ > DEV_W'(1));
    dec.bad      = !sizeOk || devRangeBad || slotBad;
    dec.isWrite  = writeQ;
    dec.needRead = !writeQ || (sizeQ != SIZE_W'(4));

    selBit    = SEL_W'(devQ) + SEL_W'(SEL_LSB);
    oneHot    = DATA_W'(1) << selBit;
    funcField = DATA_W'(funcQ) << FUNC_SHIFT;
    offField  = DATA_W'({offQ[OFF_W-1:2], 2'b00});
    t0Addr    = CFG_BASE | (oneHot & ~WIN_MASK) | funcField | offField;
    t1Addr    = CFG_BASE | (DATA_W'(busQ) << BUS_SHIFT) | (DATA_W'(devQ) << DEV_SHIFT)
              | funcField | offField;
    winNext   = isType0 ? (TYPE0_CODE | (oneHot & WIN_MASK)) : TYPE1_CODE;
  end

  assign busAddr  = isType0 ? t0Addr : t1Addr;
  assign winValue = winQ;

  // ---- byte lane handling ----
  logic [4:0]        shiftAmt;
  logic [DATA_W-1:0] sizeMask, laneMask, insertWord, mergedWord, alignedWord;

  always_comb begin
    shiftAmt = {offQ[1:0], 3'b000};
    case (sizeQ)
      SIZE_W'(1): sizeMask = 32'h0000_00FF;
      SIZE_W'(2): sizeMask = 32'h0000_FFFF;
      default:    sizeMask = 32'hFFFF_FFFF;
    endcase
    laneMask    = sizeMask << shiftAmt;
    insertWord  = (wdataQ & sizeMask) << shiftAmt;
    alignedWord = (wordQ >> shiftAmt) & sizeMask;
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign mergedWord[8*lane +: 8] = laneMask[8*lane] ? insertWord[8*lane +: 8]
                                                      : wordQ[8*lane +: 8];
  end

  assign busWdata  = (sizeQ == SIZE_W'(4)) ? wdataQ : mergedWord;
  assign doneErr   = badQ | busErrQ;
  assign doneRdata = busErrQ ? '1 : ((badQ || writeQ) ? '0 : alignedWord);

endmodule

// File: rtl/cfgx_control.sv
module cfgx_control
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  cfgxDecode_t dec,
  input  logic        busAck,
  input  logic        busErr,
  output logic        busReq,
  output logic        busWrite,
  output logic        done,
  output cfgxCtrl_t   ctrl
);

  cfgxState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    reqReady  = 1'b0;
    busReq    = 1'b0;
    busWrite  = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          stateNext     = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (dec.bad) begin
          ctrl.markBad = 1'b1;
          stateNext    = ST_DONE;
        end else begin
          ctrl.loadWin = 1'b1;
          stateNext    = dec.needRead ? ST_READ : ST_WRITE;
        end
      end
      ST_READ: begin
        busReq = 1'b1;
        if (busAck) begin
          ctrl.captureRead = 1'b1;
          stateNext = (busErr || !dec.isWrite) ? ST_DONE : ST_WRITE;
        end
      end
      ST_WRITE: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        if (busAck) begin
          ctrl.captureWrite = 1'b1;
          stateNext         = ST_DONE;
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FUNC_W     = 3,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int SLOT_COUNT = 16,
  parameter logic [31:0] CFG_BASE   = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK   = 32'hFC00_0000,
  parameter logic [31:0] TYPE0_CODE = 32'h0000_0002,
  parameter logic [31:0] TYPE1_CODE = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              singleSlot,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              done,
  output logic              doneErr,
  output logic [31:0]       doneRdata,
  output logic [31:0]       winValue,
  output logic              busReq,
  output logic              busWrite,
  output logic [31:0]       busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [31:0]       busRdata
);

  cfgxCtrl_t   ctrl;
  cfgxDecode_t dec;

  cfgx_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .dec      (dec),
    .busAck   (busAck),
    .busErr   (busErr),
    .busReq   (busReq),
    .busWrite (busWrite),
    .done     (done),
    .ctrl     (ctrl)
  );

  cfgx_datapath #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
    .SLOT_COUNT(SLOT_COUNT), .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK),
    .TYPE0_CODE(TYPE0_CODE), .TYPE1_CODE(TYPE1_CODE)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .singleSlot (singleSlot),
    .reqBus     (reqBus),
    .reqDev     (reqDev),
    .reqFunc    (reqFunc),
    .reqOff     (reqOff),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .busRdata   (busRdata),
    .busErr     (busErr),
    .dec        (dec),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .winValue   (winValue),
    .doneErr    (doneErr),
    .doneRdata  (doneRdata)
  );

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        busReq,
  input logic        busWrite,
  input logic        busAck,
  input logic        busErr,
  input logic [31:0] busAddr,
  input logic        done,
  input logic        doneErr,
  input logic [31:0] doneRdata
);

  logic sawBus, sawBusErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sawBus    <= 1'b0;
      sawBusErr <= 1'b0;
    end else if (reqValid && reqReady) begin
      sawBus    <= 1'b0;
      sawBusErr <= 1'b0;
    end else begin
      if (busReq) sawBus <= 1'b1;
      if (busReq && busAck && busErr) sawBusErr <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReq);  // R11

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr)));  // R11

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busAddr[1:0] == 2'b00));  // R1

  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (done && !sawBus) |-> (doneErr && doneRdata == 32'h0));  // R6

  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (done && sawBusErr) |-> (doneErr && doneRdata == 32'hFFFF_FFFF));  // R10

  AST_NO_WRITE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    sawBusErr |-> !(busReq && busWrite));  // R10

endmodule

bind cfgx_translator cfgx_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .busReq    (busReq),
  .busWrite  (busWrite),
  .busAck    (busAck),
  .busErr    (busErr),
  .busAddr   (busAddr),
  .done      (done),
  .doneErr   (doneErr),
  .doneRdata (doneRdata)
);

// File: tb/tb_cfgx_translator.sv
module tb_cfgx_translator;

  localparam logic [31:0] B_BASE = 32'h0C00_0000;
  localparam logic [31:0] B_MASK = 32'hFC00_0000;
  localparam logic [31:0] B_T0   = 32'h0000_0002;
  localparam logic [31:0] B_T1   = 32'h0000_0003;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic singleSlot = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [7:0] reqBus = '0;
  logic [4:0] reqDev = '0;
  logic [2:0] reqFunc = '0;
  logic [7:0] reqOff = '0;
  logic [2:0] reqSize = '0;
  logic reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic done, doneErr;
  logic [31:0] doneRdata, winValue;
  logic busReq, busWrite;
  logic [31:0] busAddr, busWdata;
  logic busAck = 1'b0;
  logic busErr = 1'b0;
  logic [31:0] busRdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  cfgx_translator dut (
    .clk(clk), .rstN(rstN), .singleSlot(singleSlot),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOff(reqOff),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .done(done), .doneErr(doneErr), .doneRdata(doneRdata), .winValue(winValue),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
  );

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  // memory-like target: word content is a function of the address
  int rdCount = 0, wrCount = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastWrData = '0;
  always @(posedge clk) begin
    busAck <= busReq && !busAck;
    busErr <= busReq && !busAck && (busAddr[7:2] == 6'h3F);
    if (busReq && !busAck) begin
      busRdata <= pattern(busAddr);
      if (busWrite) begin
        wrCount <= wrCount + 1; lastWrAddr <= busAddr; lastWrData <= busWdata;
      end else begin
        rdCount <= rdCount + 1; lastRdAddr <= busAddr;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [7:0] b, input logic [4:0] d,
                                          input logic [2:0] f, input logic [7:0] o);
    logic [31:0] a;
    if (b == 0) a = B_BASE | ((32'h1 << (d + 16)) & ~B_MASK);
    else        a = B_BASE | (32'(b) << 16) | (32'(d) << 11);
    return a | (32'(f) << 8) | 32'(o & 8'hFC);
  endfunction

  function automatic logic [31:0] expWin(input logic [7:0] b, input logic [4:0] d);
    if (b == 0) return B_T0 | ((32'h1 << (d + 16)) & B_MASK);
    return B_T1;
  endfunction

  function automatic logic [31:0] sMask(input int sz);
    return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  int preRd, preWr;
  logic [31:0] preWin;

  task automatic doReq(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                       input logic [7:0] o, input int sz, input logic wr,
                       input logic [31:0] wd, input logic ss);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    preRd = rdCount; preWr = wrCount; preWin = winValue;
    reqBus = b; reqDev = d; reqFunc = f; reqOff = o; reqSize = 3'(sz);
    reqWrite = wr; reqWdata = wd; singleSlot = ss; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 ready low in flight", 32'(reqReady), 32'h0);
    while (!done) @(negedge clk);
  endtask

  task automatic afterDone();
    @(negedge clk);
    chk("R11 done one cycle", 32'(done), 32'h0);
  endtask

  task automatic expectReject(input string tag);
    chk({tag, " err"}, 32'(doneErr), 32'h1);
    chk("R6 rdata zero", doneRdata, 32'h0);
    chk("R6 window unchanged", winValue, preWin);
    chk("R6 no bus access", 32'(rdCount + wrCount), 32'(preRd + preWr));
    afterDone();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready", 32'(reqReady), 32'h1);
    chk("R12 done", 32'(done), 32'h0);
    chk("R12 busReq", 32'(busReq), 32'h0);
    chk("R12 window", winValue, 32'h0);
    rstN = 1'b1;

    // R1 type 0 sweep: every slot, every function
    for (int d = 0; d < 16; d++) begin
      for (int f = 0; f < 8; f++) begin
        doReq(8'h0, 5'(d), 3'(f), 8'h13, 4, 1'b0, 32'h0, 1'b0);
        chk("R1 t0 address", lastRdAddr, expAddr(8'h0, 5'(d), 3'(f), 8'h13));
        chk("R1 t0 window", winValue, expWin(8'h0, 5'(d)));
        chk("R1 t0 err", 32'(doneErr), 32'h0);
        chk("R7 t0 rdata", doneRdata, pattern(expAddr(8'h0, 5'(d), 3'(f), 8'h13)) >> 24);
        afterDone();
      end
    end

    // R2 out-of-range slots on bus 0
    for (int d = 16; d < 32; d++) begin
      doReq(8'h0, 5'(d), 3'h1, 8'h04, 4, 1'b0, 32'h0, 1'b0);
      expectReject("R2");
    end

    // R3 type 1 sweep
    for (int bi = 0; bi < 4; bi++) begin
      logic [7:0] b;
      b = (bi == 0) ? 8'h01 : (bi == 1) ? 8'h02 : (bi == 2) ? 8'h80 : 8'hFF;
      for (int d = 0; d < 32; d++) begin
        for (int f = 0; f < 8; f += 5) begin
          doReq(b, 5'(d), 3'(f), 8'h28, 4, 1'b0, 32'h0, 1'b0);
          chk("R3 t1 address", lastRdAddr, expAddr(b, 5'(d), 3'(f), 8'h28));
          chk("R3 t1 window", winValue, B_T1);
          chk("R3 t1 rdata", doneRdata, pattern(expAddr(b, 5'(d), 3'(f), 8'h28)));
          afterDone();
        end
      end
    end

    // R4 illegal sizes
    for (int sz = 0; sz < 8; sz++) begin
      if (sz != 1 && sz != 2 && sz != 4) begin
        doReq(8'h01, 5'h2, 3'h0, 8'h00, sz, 1'b0, 32'h0, 1'b0);
        expectReject("R4");
      end
    end

    // R5 single-slot mode on both cycle types
    for (int bi = 0; bi < 2; bi++) begin
      for (int d = 0; d < 4; d++) begin
        doReq(8'(bi * 3), 5'(d), 3'h2, 8'h08, 4, 1'b0, 32'h0, 1'b1);
        if (d > 1) expectReject("R5");
        else begin
          chk("R5 allowed err", 32'(doneErr), 32'h0);
          chk("R5 allowed addr", lastRdAddr, expAddr(8'(bi * 3), 5'(d), 3'h2, 8'h08));
          afterDone();
        end
      end
    end

    // R7 sub-word reads at every offset and size
    for (int o = 0; o < 12; o++) begin
      for (int si = 0; si < 3; si++) begin
        int sz;
        logic [31:0] a;
        sz = 1 << si;
        a  = expAddr(8'h02, 5'h3, 3'h1, 8'(o));
        doReq(8'h02, 5'h3, 3'h1, 8'(o), sz, 1'b0, 32'h0, 1'b0);
        chk("R7 read lanes", doneRdata, (pattern(a) >> (8 * (o % 4))) & sMask(sz));
        chk("R7 one read", 32'(rdCount - preRd), 32'h1);
        afterDone();
      end
    end

    // R8 byte and halfword merged writes
    for (int o = 0; o < 8; o++) begin
      for (int sz = 1; sz <= 2; sz++) begin
        logic [31:0] a, wd, lane, exp;
        a    = expAddr(8'h00, 5'h4, 3'h3, 8'(o));
        wd   = 32'hC3D2_E1F0 ^ 32'(o * 9 + sz);
        lane = sMask(sz) << (8 * (o % 4));
        exp  = (pattern(a) & ~lane) | (((wd & sMask(sz)) << (8 * (o % 4))) & lane);
        doReq(8'h00, 5'h4, 3'h3, 8'(o), sz, 1'b1, wd, 1'b0);
        chk("R8 one read", 32'(rdCount - preRd), 32'h1);
        chk("R8 one write", 32'(wrCount - preWr), 32'h1);
        chk("R8 same address", lastWrAddr, lastRdAddr);
        chk("R8 merged word", lastWrData, exp);
        chk("R11 write rdata zero", doneRdata, 32'h0);
        afterDone();
      end
    end

    // R9 full-word writes
    for (int k = 0; k < 3; k++) begin
      logic [7:0] o;
      o = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : 8'h06;
      doReq(8'h05, 5'h7, 3'h6, o, 4, 1'b1, 32'h1234_5678 + 32'(k), 1'b0);
      chk("R9 no read", 32'(rdCount - preRd), 32'h0);
      chk("R9 one write", 32'(wrCount - preWr), 32'h1);
      chk("R9 data", lastWrData, 32'h1234_5678 + 32'(k));
      chk("R9 address", lastWrAddr, expAddr(8'h05, 5'h7, 3'h6, o));
      afterDone();
    end

    // R10 bus errors
    doReq(8'h01, 5'h1, 3'h0, 8'hFC, 2, 1'b0, 32'h0, 1'b0);
    chk("R10 read err", 32'(doneErr), 32'h1);
    chk("R10 read ones", doneRdata, 32'hFFFF_FFFF);
    afterDone();
    doReq(8'h00, 5'h2, 3'h0, 8'hFD, 1, 1'b1, 32'hAB, 1'b0);
    chk("R10 rmw err", 32'(doneErr), 32'h1);
    chk("R10 rmw ones", doneRdata, 32'hFFFF_FFFF);
    chk("R10 no write", 32'(wrCount - preWr), 32'h0);
    afterDone();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule